// File: doc/BRIEF.md
# E3 Transmit Serial Payload Input

This block sits at the entry of an E3 transmit path. The framer supplies the bit clock, and the upstream payload source shifts one bit per clock onto a single serial input. The block keeps a bit counter that walks the 1536 positions of an outbound frame. On each clock it takes one position and produces the bit for that position. Payload positions take the sampled serial bit. Overhead positions take bits the block generates itself.

Two registered strobes pace the source. The overhead-ahead indicator is high in the cycle before every overhead position, which tells the source to hold its next payload bit. The end-of-frame strobe is high while the final position of a frame is processed. The source uses it to start the next frame.

The A and N service bits each have a 2-bit source select. With select 2'b10, the serial bit present at that position is captured and sent one frame later. With any other select value, a static register bit is sent instead.

Top module: `e3_txpi_top`

## Requirements
- R1: The position counter runs 0..1535 and wraps to 0. An asynchronous reset (rst_ni low) returns it to position 0, so the first frame_end_o after reset release comes 1535 clocks later.
- R2: frame_end_o is high for exactly the one clock in which position 1535 is processed, and low in every other clock.
- R3: oh_ahead_o is high in the clock before each overhead position (0..11, 384..387, 768..771, 1152..1155) and low otherwise. In the first clock after reset release it stays low.
- R4: At a payload position, tx_bit_o in the following clock equals the ser_data_i value sampled on the rising edge that ends that position.
- R5: Positions 0..9 emit the alignment word 1111010000, with position 0 first.
- R6: When a_src_sel_i is 2'b10, position 10 emits the ser_data_i value captured at position 10 of the previous frame. That stored value is 0 after reset, and it is updated only while the select is 2'b10.
- R7: When a_src_sel_i is not 2'b10, position 10 emits a_reg_i, and ser_data_i at that position has no effect on the output.
- R8: Position 11 carries the N bit. It follows the rules of R6 and R7, using n_src_sel_i and n_reg_i.
- R9: The first four positions of each of the sets starting at 384, 768 and 1152 emit set_oh_i[3], set_oh_i[2], set_oh_i[1] and set_oh_i[0], in that order.
- R10: While rst_ni is low, oh_ahead_o, frame_end_o and tx_bit_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock shared with the payload source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial payload / service-bit input |
| a_src_sel_i | input | 2 | A-bit source select (2'b10 = serial input) |
| n_src_sel_i | input | 2 | N-bit source select (2'b10 = serial input) |
| a_reg_i | input | 1 | Static A-bit value |
| n_reg_i | input | 1 | Static N-bit value |
| set_oh_i | input | 4 | Overhead nibble for the later sets, MSB first |
| oh_ahead_o | output | 1 | High one clock before an overhead position |
| frame_end_o | output | 1 | High while the last position is processed |
| tx_bit_o | output | 1 | Assembled frame bit, one clock after its position |

## Verification
Every cycle, the assertions check the counter stepping and wrapping, the single-cycle end-of-frame strobe and its link to the last position, and that an overhead-ahead indication is always followed by an overhead position. They also check that a captured service bit never changes away from its own position, and that payload positions pass the sampled serial bit through. Several behaviours can only be shown by the bench scenarios, which compare every output bit over two frames against an independent frame model. These are the alignment word, the order of the set nibble, the one-frame delay of serially sourced A/N bits, the fact that ser_data_i has no effect under a register select, and the outputs during and after a reset in the middle of a frame.

// File: rtl/e3_txpi_pkg.sv
package e3_txpi_pkg;

  typedef enum logic [2:0] {
    K_PAY,
    K_FAS,
    K_A,
    K_N,
    K_SET
  } bit_kind_e;

  localparam logic [1:0] SRC_SERIAL = 2'b10;

  // Classify a frame position; header (alignment + A + N) wins over set overhead.
  function automatic bit_kind_e kind_of(input int unsigned pos,
                                        input int unsigned fas_len,
                                        input int unsigned set_len,
                                        input int unsigned set_oh);
    if (pos < fas_len)          return K_FAS;
    if (pos == fas_len)         return K_A;
    if (pos == fas_len + 1)     return K_N;
    if ((pos % set_len) < set_oh) return K_SET;
    return K_PAY;
  endfunction

endpackage

// File: rtl/e3_txpi_bit_counter.sv
module e3_txpi_bit_counter
  import e3_txpi_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 1536,
  parameter int unsigned FAS_LEN   = 10,
  parameter int unsigned SET_LEN   = 384,
  parameter int unsigned SET_OH    = 4,
  parameter int unsigned CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] pos_o,
  output logic             frame_end_o,
  output logic             oh_ahead_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] pos_q, pos_d, pos_dd;
  logic             fe_q, oh_q;

  always_comb begin
    pos_d  = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    pos_dd = (pos_d == LAST) ? '0 : pos_d + 1'b1;
  end

  // Strobes are registered against the next position so they are clean at reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fe_q  <= 1'b0;
      oh_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      fe_q  <= (pos_d == LAST);
      oh_q  <= (kind_of(32'(pos_dd), FAS_LEN, SET_LEN, SET_OH) != K_PAY);
    end
  end

  assign pos_o       = pos_q;
  assign frame_end_o = fe_q;
  assign oh_ahead_o  = oh_q;

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q == LAST |=> pos_q == '0);

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q != LAST |=> pos_q == $past(pos_q) + 1'b1);

  p_fe_at_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> pos_q == LAST);

  p_fe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  p_oh_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_ahead_o |=> kind_of(32'(pos_q), FAS_LEN, SET_LEN, SET_OH) != K_PAY);

endmodule

// File: rtl/e3_txpi_svc_bit.sv
module e3_txpi_svc_bit
  import e3_txpi_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned POS   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [1:0]       sel_i,
  input  logic             reg_bit_i,
  input  logic             ser_i,
  output logic             bit_o
);

  logic cap_q;
  logic at_pos, serial;

  assign at_pos = (pos_i == CNT_W'(POS));
  assign serial = (sel_i == SRC_SERIAL);

  // Captured value is used one frame later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cap_q <= 1'b0;
    else if (at_pos && serial)  cap_q <= ser_i;
  end

  assign bit_o = serial ? cap_q : reg_bit_i;

  // Shared by the A (R6) and N (R8) instances.
  p_cap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_pos |=> $stable(cap_q));

endmodule

// File: rtl/e3_txpi_assembler.sv
module e3_txpi_assembler
  import e3_txpi_pkg::*;
#(
  parameter int unsigned        FAS_LEN  = 10,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000,
  parameter int unsigned        SET_LEN  = 384,
  parameter int unsigned        SET_OH   = 4,
  parameter int unsigned        CNT_W    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              ser_i,
  input  logic              a_bit_i,
  input  logic              n_bit_i,
  input  logic [SET_OH-1:0] set_oh_i,
  output logic              tx_bit_o
);

  int unsigned       p, off;
  bit_kind_e         kind;
  logic [FAS_LEN-1:0] fas_sh;
  logic [SET_OH-1:0]  set_sh;
  logic               nxt, tx_q;

  always_comb begin
    p      = 32'(pos_i);
    off    = p % SET_LEN;
    kind   = kind_of(p, FAS_LEN, SET_LEN, SET_OH);
    fas_sh = FAS_WORD << p;
    set_sh = set_oh_i << off;
    unique case (kind)
      K_FAS:   nxt = fas_sh[FAS_LEN-1];
      K_A:     nxt = a_bit_i;
      K_N:     nxt = n_bit_i;
      K_SET:   nxt = set_sh[SET_OH-1];
      default: nxt = ser_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b0;
    else         tx_q <= nxt;
  end

  assign tx_bit_o = tx_q;

  p_payload_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == K_PAY |=> tx_bit_o == $past(ser_i));

endmodule

// File: rtl/e3_txpi_top.sv
module e3_txpi_top
  import e3_txpi_pkg::*;
#(
  parameter int unsigned        FRAME_LEN = 1536,
  parameter int unsigned        SET_LEN   = 384,
  parameter int unsigned        SET_OH    = 4,
  parameter int unsigned        FAS_LEN   = 10,
  parameter logic [FAS_LEN-1:0] FAS_WORD  = 10'b1111010000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_data_i,
  input  logic [1:0]        a_src_sel_i,
  input  logic [1:0]        n_src_sel_i,
  input  logic              a_reg_i,
  input  logic              n_reg_i,
  input  logic [SET_OH-1:0] set_oh_i,
  output logic              oh_ahead_o,
  output logic              frame_end_o,
  output logic              tx_bit_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam int unsigned A_POS = FAS_LEN;
  localparam int unsigned N_POS = FAS_LEN + 1;

  logic [CNT_W-1:0] pos;
  logic             a_bit, n_bit;

  e3_txpi_bit_counter #(
    .FRAME_LEN(FRAME_LEN), .FAS_LEN(FAS_LEN), .SET_LEN(SET_LEN),
    .SET_OH(SET_OH), .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pos_o      (pos),
    .frame_end_o(frame_end_o),
    .oh_ahead_o (oh_ahead_o)
  );

  e3_txpi_svc_bit #(.CNT_W(CNT_W), .POS(A_POS)) u_a_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos),
    .sel_i    (a_src_sel_i),
    .reg_bit_i(a_reg_i),
    .ser_i    (ser_data_i),
    .bit_o    (a_bit)
  );

  e3_txpi_svc_bit #(.CNT_W(CNT_W), .POS(N_POS)) u_n_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos),
    .sel_i    (n_src_sel_i),
    .reg_bit_i(n_reg_i),
    .ser_i    (ser_data_i),
    .bit_o    (n_bit)
  );

  e3_txpi_assembler #(
    .FAS_LEN(FAS_LEN), .FAS_WORD(FAS_WORD), .SET_LEN(SET_LEN),
    .SET_OH(SET_OH), .CNT_W(CNT_W)
  ) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pos_i   (pos),
    .ser_i   (ser_data_i),
    .a_bit_i (a_bit),
    .n_bit_i (n_bit),
    .set_oh_i(set_oh_i),
    .tx_bit_o(tx_bit_o)
  );

  // R7: a register-sourced A bit reaches the line whatever ser_data_i holds.
  p_a_reg_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == CNT_W'(A_POS) && a_src_sel_i != SRC_SERIAL) |=> tx_bit_o == $past(a_reg_i));

endmodule

// File: tb/e3_txpi_top_tb_top.sv
module e3_txpi_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FLEN = 1536;
  localparam int SLEN = 384;

  typedef struct packed {
    logic [1:0]  a_sel;
    logic [1:0]  n_sel;
    logic        a_reg;
    logic        n_reg;
    logic [3:0]  set_oh;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{a_sel: 2'b10, n_sel: 2'b10, a_reg: 1'b0, n_reg: 1'b0, set_oh: 4'b1010, seed: 16'hACE1},
    '{a_sel: 2'b00, n_sel: 2'b01, a_reg: 1'b1, n_reg: 1'b0, set_oh: 4'b0110, seed: 16'h1234},
    '{a_sel: 2'b10, n_sel: 2'b11, a_reg: 1'b0, n_reg: 1'b1, set_oh: 4'b1111, seed: 16'hBEEF},
    '{a_sel: 2'b01, n_sel: 2'b10, a_reg: 1'b1, n_reg: 1'b1, set_oh: 4'b0001, seed: 16'h0F0F}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser = 1'b0;
  logic [1:0] a_sel = 2'b00, n_sel = 2'b00;
  logic       a_reg = 1'b0, n_reg = 1'b0;
  logic [3:0] set_oh = 4'b0000;
  logic       oh_ahead, frame_end, tx_bit;

  int checks = 0;
  int failures = 0;
  int wd_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3_txpi_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ser_data_i (ser),
    .a_src_sel_i(a_sel),
    .n_src_sel_i(n_sel),
    .a_reg_i    (a_reg),
    .n_reg_i    (n_reg),
    .set_oh_i   (set_oh),
    .oh_ahead_o (oh_ahead),
    .frame_end_o(frame_end),
    .tx_bit_o   (tx_bit)
  );

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles == 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", wd_cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input int pos);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s pos=%0d act=%0b exp=%0b", tag, pos, act, exp);
    end
  endtask

  // 0 payload, 1 alignment, 2 A, 3 N, 4 set overhead
  function automatic int kind(input int p);
    if (p < 10) return 1;
    if (p == 10) return 2;
    if (p == 11) return 3;
    if ((p % SLEN) < 4) return 4;
    return 0;
  endfunction

  task automatic run_vec(input vec_t v, input int ncyc);
    logic [9:0]  fas = 10'b1111010000;
    logic [15:0] lfsr;
    logic        a_cap, n_cap, exp_prev, e;
    string       tag_prev, tag;
    int          cur, prev;
    bit          first;
    @(negedge clk);
    rst_n = 1'b0;
    a_sel = v.a_sel; n_sel = v.n_sel; a_reg = v.a_reg; n_reg = v.n_reg; set_oh = v.set_oh;
    ser = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 oh_ahead", oh_ahead, 1'b0, 0);
    chk("R10 frame_end", frame_end, 1'b0, 0);
    chk("R10 tx_bit", tx_bit, 1'b0, 0);
    rst_n = 1'b1;
    lfsr = v.seed; a_cap = 1'b0; n_cap = 1'b0;
    exp_prev = 1'b0; tag_prev = "R10 tx_bit after release";
    cur = 0; prev = 0; first = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      chk("R1 R2 frame_end", frame_end, (cur == FLEN - 1), cur);
      chk("R3 oh_ahead", oh_ahead, first ? 1'b0 : (kind((cur + 1) % FLEN) != 0), cur);
      chk(tag_prev, tx_bit, exp_prev, prev);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser = lfsr[0];
      case (kind(cur))
        1: begin e = fas[9 - cur]; tag = "R5 alignment"; end
        2: begin
          if (v.a_sel == 2'b10) begin e = a_cap; a_cap = ser; tag = "R6 A serial"; end
          else begin e = v.a_reg; tag = "R7 A register"; end
        end
        3: begin
          if (v.n_sel == 2'b10) begin e = n_cap; n_cap = ser; tag = "R8 N serial"; end
          else begin e = v.n_reg; tag = "R8 N register"; end
        end
        4: begin e = v.set_oh[3 - (cur % SLEN)]; tag = "R9 set overhead"; end
        default: begin e = ser; tag = "R4 payload"; end
      endcase
      exp_prev = e; tag_prev = tag; prev = cur; first = 1'b0;
      @(negedge clk);
      cur = (cur + 1) % FLEN;
    end
  endtask

  initial begin
    foreach (VECS[i]) run_vec(VECS[i], 2 * FLEN + 4);
    // Directed: reset in the middle of a frame, then a full run.
    run_vec(VECS[0], 700);
    run_vec(VECS[2], 2 * FLEN + 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule